// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives 16-bit words from a three-wire serial master: an active-low frame strobe, a serial clock and a data line. It decodes each word into a write to one of five registers. These are a 14-bit control register, two 28-bit frequency registers and two 12-bit phase registers. The register contents drive a synthesis datapath that runs on a separate master clock. The loader therefore hands every completed word across to that domain and applies the write there.

The two top bits of each word carry the address. A control bit chooses how frequency words are applied. In paired mode, two consecutive words to the same frequency address form one 28-bit value, with the low half first. The register takes that value in a single update. In half mode, each word replaces only one 14-bit half, and a second control bit picks which half.

Top module: `tws_reg_loader`

## Requirements
- R1: A word is 16 bits, sampled on falling `sclk` edges while `fsync_n` is low, with the most significant bit first.
- R2: While `fsync_n` stays low, every complete group of 16 falling edges forms a separate word, and each of these words is applied.
- R3: If `fsync_n` rises after fewer than 16 edges, the partial bits are dropped and change no register. The next frame starts counting from bit 15.
- R4: Address bits [15:14]=00 load `ctrl_q` from bits [13:0]. Control positions 9, 4, 2 and 0 are reserved and always read 0.
- R5: Address 11 writes a phase register from bits [11:0]. Bit 13 selects the register (0 for `phase0_q`, 1 for `phase1_q`), and bit 12 has no effect.
- R6: When control bit 13 is 1, a word with address 01 (frequency 0) or 10 (frequency 1) is held as the low 14 bits. The next word to the same address supplies the high 14 bits and updates the register with both halves at once. No intermediate value is ever visible.
- R7: In paired mode, a word to the other frequency address discards the held half and starts a new pair with itself. A control write also discards any held half.
- R8: When control bit 13 is 0, a frequency word writes bits [27:14] if control bit 12 is 1 and bits [13:0] if it is 0. The other half is kept.
- R9: The target register changes at the third rising `mclk` edge after the completing `sclk` edge. Each word changes at most one register.
- R10: Asserting `rst_n` clears every output register and any held half at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock of the register outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdata | input | 1 | Serial data, most significant bit first |
| ctrl_q | output | 14 | Control register |
| freq0_q | output | 28 | Frequency register 0 |
| freq1_q | output | 28 | Frequency register 1 |
| phase0_q | output | 12 | Phase register 0 |
| phase1_q | output | 12 | Phase register 1 |

## Verification
The stimulus table covers several corner cases, and each one catches a specific mistake:
- A paired load whose first half is visible would show a wrong frequency between its two words.
- Failing to drop the held half on a control write or on an address switch would combine halves from two different pairs.
- A truncated frame tests the counter reset: a design that keeps counting would fold the stale bits into the next word and write the wrong phase register value.
- Words sent back to back in one frame check that the handover between clock domains keeps up without losing a word.
- Each result is sampled exactly three master-clock edges after the word completes, so a design with extra or missing sync stages also fails.

// File: rtl/tws_loader_pkg.sv
`timescale 1ns/1ps
package tws_loader_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = 14;
  localparam int FREQ_W  = 2 * HALF_W;
  localparam int PHASE_W = 12;
  localparam int CTRL_W  = 14;
  localparam int ADDR_HI = WORD_W - 1;
  localparam int ADDR_LO = WORD_W - 2;
  // control positions that the decoder itself acts on
  localparam int CB_PAIR  = 13;
  localparam int CB_HIGH  = 12;
  // phase word: register select position
  localparam int PB_SEL   = 13;
  localparam logic [CTRL_W-1:0] CTRL_RSVD = 14'h0215;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'b00,
    ADDR_FREQ0 = 2'b01,
    ADDR_FREQ1 = 2'b10,
    ADDR_PHASE = 2'b11
  } addr_e;
endpackage

// File: rtl/tws_shift_in.sv
`timescale 1ns/1ps
module tws_shift_in
  import tws_loader_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fsync_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_q,
  output logic              word_tgl
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              frame_rst_n;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last_bit;
  logic [WORD_W-1:0] word_d;
  logic              tgl_d;

  // the frame strobe clears the partial word asynchronously (R3)
  assign frame_rst_n = rst_n & ~fsync_n;

  always_comb begin
    sh_d     = {sh_q[WORD_W-3:0], sdata};
    cnt_d    = cnt_q + 1'b1;
    last_bit = (cnt_q == CNT_W'(WORD_W - 1)) && !fsync_n;
    word_d   = word_q;
    tgl_d    = word_tgl;
    if (last_bit) begin
      word_d = {sh_q, sdata};
      tgl_d  = ~word_tgl;
    end
  end

  always_ff @(negedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_tgl <= 1'b0;
    end else begin
      word_q   <= word_d;
      word_tgl <= tgl_d;
    end
  end
endmodule

// File: rtl/tws_rst_sync.sv
`timescale 1ns/1ps
module tws_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/tws_toggle_sync.sv
`timescale 1ns/1ps
module tws_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic stb
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], tgl_in};
    stb     = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/tws_reg_file.sv
`timescale 1ns/1ps
module tws_reg_file
  import tws_loader_pkg::*;
(
  input  logic               mclk,
  input  logic               rst_n,
  input  logic               stb,
  input  logic [WORD_W-1:0]  word,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq_o  [2],
  output logic [PHASE_W-1:0] phase_o [2]
);
  localparam int NREG = 2;

  addr_e              addr;
  logic [HALF_W-1:0]  payload;
  logic               fsel;
  logic [CTRL_W-1:0]  ctrl_d;
  logic [FREQ_W-1:0]  freq_d  [NREG];
  logic [PHASE_W-1:0] phase_d [NREG];
  logic               pend_q, pend_d;
  logic               pend_sel_q, pend_sel_d;
  logic [HALF_W-1:0]  pend_lo_q, pend_lo_d;

  always_comb begin
    addr       = addr_e'(word[ADDR_HI:ADDR_LO]);
    payload    = word[HALF_W-1:0];
    fsel       = (addr == ADDR_FREQ1);
    ctrl_d     = ctrl_o;
    freq_d     = freq_o;
    phase_d    = phase_o;
    pend_d     = pend_q;
    pend_sel_d = pend_sel_q;
    pend_lo_d  = pend_lo_q;
    if (stb) begin
      unique case (addr)
        ADDR_CTRL: begin
          ctrl_d = payload & ~CTRL_RSVD;
          pend_d = 1'b0;
        end
        ADDR_FREQ0, ADDR_FREQ1: begin
          if (ctrl_o[CB_PAIR]) begin
            if (pend_q && (pend_sel_q == fsel)) begin
              freq_d[fsel] = {payload, pend_lo_q};
              pend_d       = 1'b0;
            end else begin
              pend_d     = 1'b1;
              pend_sel_d = fsel;
              pend_lo_d  = payload;
            end
          end else if (ctrl_o[CB_HIGH]) begin
            freq_d[fsel][FREQ_W-1:HALF_W] = payload;
          end else begin
            freq_d[fsel][HALF_W-1:0] = payload;
          end
        end
        ADDR_PHASE: begin
          phase_d[word[PB_SEL]] = word[PHASE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o     <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
      pend_lo_q  <= '0;
    end else begin
      ctrl_o     <= ctrl_d;
      pend_q     <= pend_d;
      pend_sel_q <= pend_sel_d;
      pend_lo_q  <= pend_lo_d;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_regs
    always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
        freq_o[gi]  <= '0;
        phase_o[gi] <= '0;
      end else begin
        freq_o[gi]  <= freq_d[gi];
        phase_o[gi] <= phase_d[gi];
      end
    end
  end
endmodule

// File: rtl/tws_reg_loader.sv
`timescale 1ns/1ps
module tws_reg_loader
  import tws_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               mclk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               fsync_n,
  input  logic               sdata,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [FREQ_W-1:0]  freq0_q,
  output logic [FREQ_W-1:0]  freq1_q,
  output logic [PHASE_W-1:0] phase0_q,
  output logic [PHASE_W-1:0] phase1_q
);
  logic [WORD_W-1:0]  ser_word;
  logic               ser_tgl;
  logic               rst_sync_n;
  logic               word_stb;
  logic [FREQ_W-1:0]  freq_w  [2];
  logic [PHASE_W-1:0] phase_w [2];

  tws_shift_in u_shift (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .fsync_n (fsync_n),
    .sdata   (sdata),
    .word_q  (ser_word),
    .word_tgl(ser_tgl)
  );

  tws_rst_sync u_rst (
    .clk   (mclk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  tws_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .mclk  (mclk),
    .rst_n (rst_sync_n),
    .tgl_in(ser_tgl),
    .stb   (word_stb)
  );

  tws_reg_file u_regs (
    .mclk   (mclk),
    .rst_n  (rst_sync_n),
    .stb    (word_stb),
    .word   (ser_word),
    .ctrl_o (ctrl_q),
    .freq_o (freq_w),
    .phase_o(phase_w)
  );

  assign freq0_q  = freq_w[0];
  assign freq1_q  = freq_w[1];
  assign phase0_q = phase_w[0];
  assign phase1_q = phase_w[1];
endmodule

// File: rtl/tws_reg_loader_chk.sv
`timescale 1ns/1ps
module tws_reg_loader_chk
  import tws_loader_pkg::*;
(
  input logic               mclk,
  input logic               rst_n,
  input logic               stb,
  input logic               pair_mode,
  input logic [CTRL_W-1:0]  ctrl,
  input logic [FREQ_W-1:0]  f0,
  input logic [FREQ_W-1:0]  f1,
  input logic [PHASE_W-1:0] p0,
  input logic [PHASE_W-1:0] p1
);
  assert_one_update_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    $countones({f0 != $past(f0), f1 != $past(f1), p0 != $past(p0),
                p1 != $past(p1), ctrl != $past(ctrl)}) <= 1);

  assert_update_needs_word_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    ({f0 != $past(f0), f1 != $past(f1), p0 != $past(p0),
      p1 != $past(p1), ctrl != $past(ctrl)} != 5'b0) |-> $past(stb));

  assert_strobe_single_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    stb |=> !stb);

  assert_half_kept_f0_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$past(pair_mode) && (f0 != $past(f0))) |->
      ((f0[FREQ_W-1:HALF_W] == $past(f0[FREQ_W-1:HALF_W])) ||
       (f0[HALF_W-1:0] == $past(f0[HALF_W-1:0]))));

  assert_half_kept_f1_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$past(pair_mode) && (f1 != $past(f1))) |->
      ((f1[FREQ_W-1:HALF_W] == $past(f1[FREQ_W-1:HALF_W])) ||
       (f1[HALF_W-1:0] == $past(f1[HALF_W-1:0]))));
endmodule

bind tws_reg_loader tws_reg_loader_chk chk_i (
  .mclk     (mclk),
  .rst_n    (rst_sync_n),
  .stb      (word_stb),
  .pair_mode(ctrl_q[13]),
  .ctrl     (ctrl_q),
  .f0       (freq0_q),
  .f1       (freq1_q),
  .p0       (phase0_q),
  .p1       (phase1_q)
);

// File: tb/tws_reg_loader_tb_top.sv
`timescale 1ns/1ps
module tws_reg_loader_tb_top;
  localparam int NVEC = 17;
  // {word16, ctrl14, freq0 28, freq1 28, phase0 12, phase1 12}
  localparam logic [109:0] VEC [NVEC] = '{
    {16'h2000, 14'h2000, 28'h0000000, 28'h0000000, 12'h000, 12'h000}, // R4 R6 pair mode on
    {16'h4000, 14'h2000, 28'h0000000, 28'h0000000, 12'h000, 12'h000}, // R6 low half held
    {16'h7FFF, 14'h2000, 28'hFFFC000, 28'h0000000, 12'h000, 12'h000}, // R6 commit
    {16'h0000, 14'h0000, 28'hFFFC000, 28'h0000000, 12'h000, 12'h000}, // R4 half mode
    {16'hBFFF, 14'h0000, 28'hFFFC000, 28'h0003FFF, 12'h000, 12'h000}, // R8 low half f1
    {16'h1000, 14'h1000, 28'hFFFC000, 28'h0003FFF, 12'h000, 12'h000}, // R8 high select
    {16'h40FF, 14'h1000, 28'h03FC000, 28'h0003FFF, 12'h000, 12'h000}, // R8 high half f0
    {16'hC123, 14'h1000, 28'h03FC000, 28'h0003FFF, 12'h123, 12'h000}, // R5 phase0
    {16'hF456, 14'h1000, 28'h03FC000, 28'h0003FFF, 12'h123, 12'h456}, // R5 phase1, bit12 set
    {16'h2FFF, 14'h2DEA, 28'h03FC000, 28'h0003FFF, 12'h123, 12'h456}, // R4 reserved cleared
    {16'h8005, 14'h2DEA, 28'h03FC000, 28'h0003FFF, 12'h123, 12'h456}, // R6 f1 low held
    {16'h4001, 14'h2DEA, 28'h03FC000, 28'h0003FFF, 12'h123, 12'h456}, // R7 address switch
    {16'h4002, 14'h2DEA, 28'h0008001, 28'h0003FFF, 12'h123, 12'h456}, // R7 pair f0
    {16'h8007, 14'h2DEA, 28'h0008001, 28'h0003FFF, 12'h123, 12'h456}, // R7 f1 low held
    {16'h2000, 14'h2000, 28'h0008001, 28'h0003FFF, 12'h123, 12'h456}, // R7 control drops it
    {16'h8009, 14'h2000, 28'h0008001, 28'h0003FFF, 12'h123, 12'h456}, // R7 fresh low half
    {16'h8001, 14'h2000, 28'h0008001, 28'h0004009, 12'h123, 12'h456}  // R6 commit f1
  };

  logic        mclk = 1'b0;
  logic        rst_n, sclk, fsync_n, sdata;
  logic [13:0] ctrl_q;
  logic [27:0] freq0_q, freq1_q;
  logic [11:0] phase0_q, phase1_q;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 mclk = ~mclk;

  tws_reg_loader dut_i (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
    .ctrl_q(ctrl_q), .freq0_q(freq0_q), .freq1_q(freq1_q),
    .phase0_q(phase0_q), .phase1_q(phase1_q)
  );

  task automatic cmp(string tag, string name, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [13:0] ec, logic [27:0] ef0, logic [27:0] ef1,
                         logic [11:0] ep0, logic [11:0] ep1);
    cmp(tag, "ctrl",   28'(ctrl_q),   28'(ec));
    cmp(tag, "freq0",  freq0_q,       ef0);
    cmp(tag, "freq1",  freq1_q,       ef1);
    cmp(tag, "phase0", 28'(phase0_q), 28'(ep0));
    cmp(tag, "phase1", 28'(phase1_q), 28'(ep1));
  endtask

  task automatic start_frame();
    @(negedge mclk);
    sclk    = 1'b1;
    fsync_n = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge mclk);
    fsync_n = 1'b1;
    sclk    = 1'b1;
  endtask

  // R1: most significant bit first, sampled on the falling edge
  task automatic shift_bits(logic [15:0] w, int n);
    for (int b = 0; b < n; b++) begin
      @(negedge mclk);
      sclk  = 1'b1;
      sdata = w[15-b];
      @(negedge mclk);
      @(negedge mclk);
      sclk = 1'b0;
    end
  endtask

  // R9: sample just after the third rising master-clock edge
  task automatic wait_apply();
    repeat (3) @(posedge mclk);
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fsync_n = 1'b1; sclk = 1'b1; sdata = 1'b0;
    repeat (4) @(posedge mclk);
    #1;
    chk_all("R10 reset", 14'h0, 28'h0, 28'h0, 12'h0, 12'h0);
    @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(posedge mclk);

    // R1 R4 R5 R6 R7 R8 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      start_frame();
      shift_bits(VEC[i][109:94], 16);
      wait_apply();
      chk_all($sformatf("R1/R9 vector %0d", i), VEC[i][93:80], VEC[i][79:52],
              VEC[i][51:24], VEC[i][23:12], VEC[i][11:0]);
      end_frame();
    end

    // R3: truncated frame changes nothing, next frame starts clean
    start_frame();
    shift_bits(16'hC300, 8);
    end_frame();
    repeat (6) @(posedge mclk);
    #1;
    chk_all("R3 partial", 14'h2000, 28'h0008001, 28'h0004009, 12'h123, 12'h456);
    start_frame();
    shift_bits(16'hC00A, 16);
    wait_apply();
    chk_all("R3 after partial", 14'h2000, 28'h0008001, 28'h0004009, 12'h00A, 12'h456);
    end_frame();

    // R2: two words inside one frame
    start_frame();
    shift_bits(16'hC00B, 16);
    wait_apply();
    chk_all("R2 word one", 14'h2000, 28'h0008001, 28'h0004009, 12'h00B, 12'h456);
    shift_bits(16'hE00C, 16);
    wait_apply();
    chk_all("R2 word two", 14'h2000, 28'h0008001, 28'h0004009, 12'h00B, 12'h00C);
    end_frame();

    // R10: reset mid-run clears everything at once
    @(negedge mclk);
    rst_n = 1'b0;
    #1;
    chk_all("R10 mid reset", 14'h0, 28'h0, 28'h0, 12'h0, 12'h0);
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(posedge mclk);
    // R8 R10: control back to half mode, low half write
    start_frame();
    shift_bits(16'h5555, 16);
    wait_apply();
    chk_all("R8/R10 after reset", 14'h0, 28'h0001555, 28'h0, 12'h0, 12'h0);
    end_frame();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule